// File: doc/BRIEF.md
# Receive Checksum Offload Engine

This block sits in the receive data path of an Ethernet MAC, between the byte stream coming off the wire side and the receive FIFO. Frames arrive one byte per handshake, the final byte flagged by a last marker. While a frame flows through, the block walks its link-layer header to find the first byte of the network-layer payload. It then accumulates a 16-bit ones-complement checksum from that byte onward, leaving out the trailing frame check sequence. Data is forwarded untouched and with no added latency. Right after the final frame byte the block emits the two checksum bytes, so software gets the payload sum without touching the data. It also reports the frame length, grown by two.

Both stream interfaces are valid/ready. A byte moves when valid and ready are both high on a rising clock edge. A source that raises valid holds valid, data and last until the byte is taken. Outside the checksum append, input ready follows output ready directly, so back-pressure from the FIFO side reaches the source in the same cycle. During the two append cycles, input ready is held low. Two plain configuration inputs, an enable and a mode select, are captured with the first byte of each frame.

Top module: `rx_csum_offload`

## Requirements
- R1: Every input byte is forwarded unchanged and in order. Outside the append, out_valid equals in_valid, out_data equals in_data, and in_ready equals out_ready.
- R2: With no tag, the two bytes at frame offsets 12 and 13 are the type field, taken big-endian. A value of 0x0600 or more marks an Ethernet II frame, and summing starts at offset 14.
- R3: A type value of 0x8100 is a tag. The tag and the 2-byte field that follows it are skipped, and the type field is then read 4 bytes later. At most two tags are skipped. A third 0x8100 (offsets 20-21) counts as the type, and summing starts at offset 22.
- R4: A type value below 0x0600 is a length. An 8-byte LLC/SNAP header follows it, and summing starts 10 bytes after the first byte of that field (offset 22 with no tags).
- R5: The checksum is the 16-bit ones-complement sum, with end-around carry, of big-endian byte pairs counted from the start byte. The last 4 bytes of the frame are left out. An odd final byte is paired with a zero low byte. The high byte is emitted right after the last frame byte and the low byte after it. out_last marks only the low byte, and in_ready stays low while both bytes are emitted.
- R6: When enabled, the reported length is the input byte count plus 2. len_valid pulses for one cycle in the cycle after the handshake of the byte carrying out_last, and len_bytes holds the length during that pulse.
- R7: When the enable captured for a frame is 0, nothing is appended. out_last marks the final frame byte, and the reported length equals the input byte count.
- R8: With mode 1 captured, no header is parsed, and summing starts at offset 0.
- R9: When no byte from the start offset onward lies outside the last 4 bytes, the appended checksum is 0x0000. This covers a frame that ends before its header is parsed. The length still grows by 2.
- R10: cfg_enable and cfg_mode are sampled only with the first byte of a frame. A change later in the frame has no effect on that frame.
- R11: While out_valid is high and out_ready is low, out_valid, out_data and out_last hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_enable | input | 1 | Checksum append enable, captured per frame |
| cfg_mode | input | 1 | 0: sum from the parsed payload start; 1: sum from byte 0 |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block accepts the input byte |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Input byte is the last of its frame |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | FIFO side accepts the output byte |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Output byte ends the frame (checksum low byte when appending) |
| len_valid | output | 1 | One-cycle pulse: len_bytes is valid |
| len_bytes | output | CNT_W (16) | Output frame length in bytes |

## Verification
The bench builds the block with its default parameters: a 16-bit byte counter, a 4-byte trailing check sequence and a limit of two tags. Frames of up to about 100 bytes therefore reach every header depth the parser handles. This includes three stacked 0x8100 values, a length field with LLC/SNAP, and frames that end inside the header or inside the trailing 4 bytes. Random idle gaps on the input and random back-pressure on the output push the two-byte append and the length pulse through stalled cycles.

// File: rtl/rxcoe_pkg.sv
`timescale 1ns/1ps
package rxcoe_pkg;

  typedef enum logic [1:0] {
    EMIT_PASS  = 2'd0,
    EMIT_SUMHI = 2'd1,
    EMIT_SUMLO = 2'd2
  } emit_state_e;

  localparam logic [15:0] VLAN_TPID = 16'h8100;
  localparam logic [15:0] TYPE_MIN  = 16'h0600;

  // 16-bit ones-complement addition with end-around carry
  function automatic logic [15:0] oc_add(input logic [15:0] a, input logic [15:0] b);
    logic [16:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[15:0] + {15'd0, s[16]};
  endfunction

endpackage

// File: rtl/rxcoe_hdr_parse.sv
`timescale 1ns/1ps
module rxcoe_hdr_parse #(
  parameter int CNT_W    = 16,
  parameter int MAX_TAGS = 2,
  parameter int TYPE_POS = 12,
  parameter int SNAP_LEN = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic             last,
  input  logic [7:0]       byte_in,
  input  logic [CNT_W-1:0] idx,
  input  logic             whole_frame,
  output logic             elig
);
  import rxcoe_pkg::*;

  localparam int TAG_W = $clog2(MAX_TAGS + 1);
  localparam logic [CNT_W-1:0] POS0 = CNT_W'(TYPE_POS);

  logic [CNT_W-1:0] tpos_q, start_q;
  logic [TAG_W-1:0] tags_q;
  logic [7:0]       hi_q;
  logic             found_q;
  logic [15:0]      type_val;
  logic             is_tag;

  always_comb begin
    type_val = {hi_q, byte_in};
    is_tag   = (type_val == VLAN_TPID) && (tags_q < TAG_W'(MAX_TAGS));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tpos_q  <= POS0;
      start_q <= '0;
      tags_q  <= '0;
      hi_q    <= '0;
      found_q <= 1'b0;
    end else if (fire) begin
      if (last) begin
        tpos_q  <= POS0;
        tags_q  <= '0;
        found_q <= 1'b0;
      end else if (!found_q) begin
        if (idx == tpos_q) hi_q <= byte_in;
        if (idx == tpos_q + CNT_W'(1)) begin
          if (is_tag) begin
            tags_q <= tags_q + TAG_W'(1);
            tpos_q <= tpos_q + CNT_W'(4);
          end else begin
            found_q <= 1'b1;
            start_q <= (type_val < TYPE_MIN) ? tpos_q + CNT_W'(2 + SNAP_LEN)
                                             : tpos_q + CNT_W'(2);
          end
        end
      end
    end
  end

  assign elig = whole_frame | (found_q && (idx >= start_q));

endmodule

// File: rtl/rxcoe_tail_delay.sv
`timescale 1ns/1ps
module rxcoe_tail_delay #(
  parameter int DEPTH = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fire,
  input  logic       last,
  input  logic [7:0] din,
  input  logic       use_in,
  output logic [7:0] dout,
  output logic       use_out
);
  logic [7:0] d_q [DEPTH];
  logic       u_q [DEPTH];
  logic [7:0] d_src [DEPTH];
  logic       u_src [DEPTH];

  for (genvar k = 0; k < DEPTH; k++) begin : g_stage
    if (k == 0) begin : g_head
      assign d_src[k] = din;
      assign u_src[k] = use_in;
    end else begin : g_body
      assign d_src[k] = d_q[k-1];
      assign u_src[k] = u_q[k-1];
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        d_q[k] <= '0;
        u_q[k] <= 1'b0;
      end else if (fire) begin
        d_q[k] <= d_src[k];
        u_q[k] <= last ? 1'b0 : u_src[k];
      end
    end
  end

  assign dout    = d_q[DEPTH-1];
  assign use_out = u_q[DEPTH-1];

endmodule

// File: rtl/rxcoe_csum.sv
`timescale 1ns/1ps
module rxcoe_csum (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        fire,
  input  logic        last,
  input  logic        add_en,
  input  logic [7:0]  add_byte,
  output logic [15:0] csum
);
  import rxcoe_pkg::*;

  logic [15:0] acc_q, acc_n, fin;
  logic [7:0]  hi_q, hi_n;
  logic        pend_q, pend_n;

  always_comb begin
    acc_n  = acc_q;
    hi_n   = hi_q;
    pend_n = pend_q;
    if (add_en) begin
      if (pend_q) begin
        acc_n  = oc_add(acc_q, {hi_q, add_byte});
        pend_n = 1'b0;
      end else begin
        hi_n   = add_byte;
        pend_n = 1'b1;
      end
    end
    fin = pend_n ? oc_add(acc_n, {hi_n, 8'h00}) : acc_n;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q  <= '0;
      hi_q   <= '0;
      pend_q <= 1'b0;
      csum   <= '0;
    end else if (fire) begin
      if (last) begin
        csum   <= fin;
        acc_q  <= '0;
        pend_q <= 1'b0;
      end else begin
        acc_q  <= acc_n;
        hi_q   <= hi_n;
        pend_q <= pend_n;
      end
    end
  end

endmodule

// File: rtl/rx_csum_offload.sv
`timescale 1ns/1ps
module rx_csum_offload #(
  parameter int CNT_W     = 16,
  parameter int FCS_BYTES = 4,
  parameter int MAX_TAGS  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_enable,
  input  logic             cfg_mode,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_data,
  input  logic             in_last,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_data,
  output logic             out_last,
  output logic             len_valid,
  output logic [CNT_W-1:0] len_bytes
);
  import rxcoe_pkg::*;

  emit_state_e      st_q;
  logic [CNT_W-1:0] idx_q, nbytes_q;
  logic             en_q, mode_q;
  logic             sof, en_cur, mode_cur;
  logic             fire, out_fire;
  logic             elig, tail_use;
  logic [7:0]       tail_byte;
  logic [15:0]      csum;

  assign sof      = (idx_q == '0);
  assign en_cur   = sof ? cfg_enable : en_q;
  assign mode_cur = sof ? cfg_mode   : mode_q;

  always_comb begin
    case (st_q)
      EMIT_SUMHI: begin
        in_ready = 1'b0; out_valid = 1'b1; out_data = csum[15:8]; out_last = 1'b0;
      end
      EMIT_SUMLO: begin
        in_ready = 1'b0; out_valid = 1'b1; out_data = csum[7:0]; out_last = 1'b1;
      end
      default: begin
        in_ready  = out_ready;
        out_valid = in_valid;
        out_data  = in_data;
        out_last  = in_last && !en_cur;
      end
    endcase
  end

  assign fire     = in_valid && in_ready;
  assign out_fire = out_valid && out_ready;

  rxcoe_hdr_parse #(.CNT_W(CNT_W), .MAX_TAGS(MAX_TAGS)) u_parse (
    .clk(clk), .rst_n(rst_n), .fire(fire), .last(in_last),
    .byte_in(in_data), .idx(idx_q), .whole_frame(mode_cur), .elig(elig)
  );

  rxcoe_tail_delay #(.DEPTH(FCS_BYTES)) u_tail (
    .clk(clk), .rst_n(rst_n), .fire(fire), .last(in_last),
    .din(in_data), .use_in(elig), .dout(tail_byte), .use_out(tail_use)
  );

  rxcoe_csum u_sum (
    .clk(clk), .rst_n(rst_n), .fire(fire), .last(in_last),
    .add_en(fire && tail_use), .add_byte(tail_byte), .csum(csum)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= EMIT_PASS;
      idx_q     <= '0;
      nbytes_q  <= '0;
      en_q      <= 1'b0;
      mode_q    <= 1'b0;
      len_valid <= 1'b0;
      len_bytes <= '0;
    end else begin
      len_valid <= out_fire && out_last;
      if (out_fire && out_last)
        len_bytes <= (st_q == EMIT_PASS) ? idx_q + CNT_W'(1) : nbytes_q;
      if (fire) begin
        if (sof) begin
          en_q   <= cfg_enable;
          mode_q <= cfg_mode;
        end
        if (in_last) begin
          idx_q    <= '0;
          nbytes_q <= idx_q + CNT_W'(3);
          if (en_cur) st_q <= EMIT_SUMHI;
        end else if (idx_q != '1) begin
          idx_q <= idx_q + CNT_W'(1);
        end
      end
      if (out_fire && st_q == EMIT_SUMHI) st_q <= EMIT_SUMLO;
      if (out_fire && st_q == EMIT_SUMLO) st_q <= EMIT_PASS;
    end
  end

endmodule

// File: rtl/rx_csum_offload_chk.sv
`timescale 1ns/1ps
module rx_csum_offload_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic       in_last,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic       out_last,
  input logic       len_valid
);

  assert_ready_path_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> out_ready);

  assert_append_starts_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_last && !out_last) |=> (out_valid && !in_ready && !out_last));

  assert_append_pair_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !in_ready && !out_last) |=> (out_valid && !in_ready && out_last));

  assert_len_after_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
    len_valid |-> $past(out_valid && out_ready && out_last));

  assert_len_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last) |=> len_valid);

  assert_hold_on_stall_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

endmodule

bind rx_csum_offload rx_csum_offload_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_last(in_last), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .out_last(out_last), .len_valid(len_valid)
);

// File: tb/tb_rx_csum_offload.sv
`timescale 1ns/1ps
module tb_rx_csum_offload;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_enable = 1'b0, cfg_mode = 1'b0;
  logic        in_valid = 1'b0, in_last = 1'b0, out_ready = 1'b0;
  logic [7:0]  in_data = 8'h00;
  logic        in_ready, out_valid, out_last, len_valid;
  logic [7:0]  out_data;
  logic [15:0] len_bytes;

  int n_checks = 0, n_fail = 0;
  logic [7:0] fr [0:127];
  logic [7:0] ob [0:135];

  always #5 clk = ~clk;

  rx_csum_offload dut (.*);

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] model_sum(input int n, input bit mode);
    int s, p, tags;
    logic [31:0] acc;
    logic [15:0] t;
    s = -1;
    if (mode) s = 0;
    else begin
      p = 12; tags = 0;
      while (p + 1 < n) begin
        t = {fr[p], fr[p+1]};
        if (t == 16'h8100 && tags < 2) begin tags++; p += 4; end
        else begin s = (t < 16'h0600) ? p + 10 : p + 2; break; end
      end
    end
    if (s < 0) return 16'h0000;
    acc = 0;
    for (int i = s; i < n - 4; i += 2) begin
      acc = acc + {16'h0, fr[i], (i + 1 < n - 4) ? fr[i+1] : 8'h00};
      acc = {16'h0, acc[15:0]} + {16'h0, acc[31:16]};
    end
    return acc[15:0];
  endfunction

  // kind: 0 ethertype, 1..3 tags (3 = three 0x8100), 4 length + SNAP
  task automatic build(input int n, input int kind);
    int p;
    for (int i = 0; i < n; i++) fr[i] = 8'($urandom);
    p = 12;
    for (int k = 0; k < kind && kind < 4; k++) begin
      if (p + 1 < n) begin fr[p] = 8'h81; fr[p+1] = 8'h00; end
      p += 4;
    end
    if (kind == 3) return;
    if (p + 1 < n) begin
      fr[p]   = (kind == 4) ? 8'h00 : 8'h08;
      fr[p+1] = (kind == 4) ? 8'h40 : 8'h00;
    end
  endtask

  task automatic run_frame(input int n, input bit en, input bit mode, input int gap,
                           input int bp, input bit flip, input string req);
    int sent = 0, got = 0, cyc = 0, lastpos = -1, len_seen = -1, bad = -1;
    int exp_len;
    bit acc = 0, flipped = 0, done = 0;
    logic [15:0] exp_sum;
    exp_len = en ? n + 2 : n;
    exp_sum = model_sum(n, mode);
    @(negedge clk);
    cfg_enable = en; cfg_mode = mode;
    while (!done && cyc < 3000) begin
      @(negedge clk);
      if (acc) begin in_valid = 1'b0; acc = 0; end
      if (!in_valid && sent < n && ($urandom % 100) >= gap) begin
        in_valid = 1'b1; in_data = fr[sent]; in_last = (sent == n - 1);
      end
      out_ready = (($urandom % 100) >= bp);
      if (flip && !flipped && sent == n / 2) begin
        cfg_enable = !en; cfg_mode = !mode; flipped = 1;
      end
      #4;
      if (in_valid && in_ready) begin sent++; acc = 1; end
      if (out_valid && out_ready) begin
        if (got < 136) ob[got] = out_data;
        if (out_last) lastpos = got;
        got++;
      end
      if (len_valid) begin len_seen = int'(len_bytes); done = 1; end
      cyc++;
    end
    if (acc) begin @(negedge clk); in_valid = 1'b0; end
    cfg_enable = en; cfg_mode = mode;
    check(done, req, "watchdog: frame completed", int'(done), 1);
    check(got == exp_len, en ? "R5" : "R7", "output byte count", got, exp_len);
    for (int i = 0; i < n && i < got; i++) if (bad < 0 && ob[i] !== fr[i]) bad = i;
    check(bad < 0, "R1", "forwarded data mismatch at index", bad, -1);
    check(lastpos == exp_len - 1, en ? "R5" : "R7", "out_last position", lastpos, exp_len - 1);
    check(len_seen == exp_len, en ? "R6" : "R7", "reported length", len_seen, exp_len);
    if (en && got >= n + 2)
      check({ob[n], ob[n+1]} == exp_sum, req, "appended checksum",
            int'({ob[n], ob[n+1]}), int'(exp_sum));
  endtask

  initial begin
    void'($urandom(32'h5EED_0C5E));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    out_ready = 1'b1;
    #4;
    check(!out_valid && !len_valid, "R1", "reset: outputs idle", int'(out_valid), 0);
    check(in_ready == out_ready, "R1", "reset: in_ready follows out_ready", int'(in_ready), 1);

    // directed corner cases
    build(40, 0); run_frame(40, 1, 0, 0, 0, 0, "R2");
    build(41, 0); run_frame(41, 1, 0, 0, 0, 0, "R5");    // odd payload
    build(50, 1); run_frame(50, 1, 0, 0, 0, 0, "R3");
    build(50, 2); run_frame(50, 1, 0, 0, 0, 0, "R3");
    build(50, 3); run_frame(50, 1, 0, 0, 0, 0, "R3");    // third tag is the type
    build(48, 4); run_frame(48, 1, 0, 0, 0, 0, "R4");
    build(13, 0); run_frame(13, 1, 0, 0, 0, 0, "R9");    // header cut off
    build(18, 0); run_frame(18, 1, 0, 0, 0, 0, "R9");    // payload only FCS
    build(3, 0);  run_frame(3, 1, 1, 0, 0, 0, "R9");
    build(1, 0);  run_frame(1, 1, 0, 0, 0, 0, "R9");
    build(30, 0); run_frame(30, 0, 0, 0, 0, 0, "R7");
    build(33, 2); run_frame(33, 1, 1, 0, 0, 0, "R8");
    build(44, 0); run_frame(44, 1, 0, 10, 0, 1, "R10");  // cfg flipped mid-frame
    build(44, 4); run_frame(44, 0, 1, 10, 0, 1, "R10");
    build(60, 1); run_frame(60, 1, 0, 30, 70, 0, "R11"); // heavy back-pressure

    // constrained random
    for (int f = 0; f < 60; f++) begin
      int n, kind, gap, bp;
      bit en, mode;
      string req;
      n = 20 + int'($urandom % 90);
      kind = int'($urandom % 5);
      en = ($urandom % 4) != 0;
      mode = ($urandom % 4) == 0;
      gap = int'($urandom % 50);
      bp = int'($urandom % 50);
      build(n, kind);
      if (!en) req = "R7";
      else if (mode) req = "R8";
      else if (kind == 0) req = "R2";
      else if (kind == 4) req = "R4";
      else req = "R3";
      run_frame(n, en, mode, gap, bp, 0, req);
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule